// File: doc/BRIEF.md
# Cascaded Dual Interrupt Priority Resolver

This block tracks interrupt requests for a pair of eight-input controllers in which the second (downstream) controller feeds input 2 of the first (upstream) one, giving sixteen request lines. Request sources post raise and lower events by line number, and the block keeps both request registers current. From the request, mask and cascade-map state it reports whether any unmasked interrupt is waiting. It picks one winning line and presents its interrupt vector.

When the processor accepts the presented vector, it pulses the acknowledge input. The block then marks the winning line as in service and drops its request if that input is edge-triggered. Each controller has an eight-bit trigger-mode register that software writes at a fixed address. Vector bases, masks and the cascade map are not decoded here; they arrive as plain inputs from the command-word logic around the block.

Top module: `cascade_irq_resolver`

## Requirements
- R1: After reset, every request, in-service and trigger-mode bit is 0, `pending` and `vec_valid` are low, and `vector` and `win_line` are 0.
- R2: An event with `ev_valid` high on line L in 0..7 (L not 2) sets (`ev_raise`=1) or clears (`ev_raise`=0) upstream request bit L at the next clock edge. An event on a line of 16 or above changes nothing.
- R3: An event naming line 2 acts exactly as the same event on line 9.
- R4: Raising line L in 8..15 sets downstream request bit L-8 and upstream request bit 2. Lowering it clears bit L-8, and it also clears upstream bit 2 when no downstream request bit is left that `slv_mask` leaves open.
- R5: `pending` is high when some upstream bit is requested, unmasked and not marked in `cascade_map`, or when `mst_mask[2]` is 0 and some downstream request is unmasked.
- R6: The winner is the first eligible line in this order: upstream 0, 1, then downstream lines 8 through 15 (only while `mst_mask[2]` is 0), then upstream 3 through 7. An upstream line is eligible when it is requested, unmasked and not set in `cascade_map`. `win_line` gives the line number 0..15.
- R7: `vector` is `mst_base`+L for a winner L in 0..7 and `slv_base`+(L-8) for L in 8..15, modulo 256. While `vec_valid` is low, `vector` and `win_line` are 0.
- R8: `ack` with an upstream winner L sets upstream in-service bit L at the next edge, and it clears request bit L only if upstream trigger bit L is 0 (edge).
- R9: `ack` with a downstream winner L sets downstream in-service bit L-8 and upstream in-service bit 2. It clears downstream request bit L-8 if downstream trigger bit L-8 is 0, and it clears upstream request bit 2 if upstream trigger bit 2 is 0.
- R10: A `cfg_wr` to address 0x4D0 loads the upstream trigger register with `cfg_wdata` AND 0xF8, and one to 0x4D1 loads the downstream register with `cfg_wdata` AND 0xDE. A write to any other address changes neither. A trigger bit of 1 means level, 0 means edge.
- R11: `ack` while `vec_valid` is low leaves every request and in-service bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Request event strobe |
| ev_raise | input | 1 | 1 raises the line, 0 lowers it |
| ev_line | input | 5 | Line number of the event |
| ack | input | 1 | Processor accepts the presented vector |
| cfg_wr | input | 1 | Trigger-mode register write strobe |
| cfg_addr | input | 12 | Trigger-mode register address |
| cfg_wdata | input | 8 | Trigger-mode write data |
| mst_base | input | 8 | Upstream vector base |
| slv_base | input | 8 | Downstream vector base |
| mst_mask | input | 8 | Upstream mask, 1 masks |
| slv_mask | input | 8 | Downstream mask, 1 masks |
| cascade_map | input | 8 | Upstream inputs that carry a cascade |
| pending | output | 1 | Some unmasked interrupt is waiting |
| vec_valid | output | 1 | A winner is presented |
| vector | output | 8 | Vector of the winner |
| win_line | output | 4 | Line number of the winner |
| mst_req | output | 8 | Upstream request register |
| slv_req | output | 8 | Downstream request register |
| mst_isr | output | 8 | Upstream in-service register |
| slv_isr | output | 8 | Downstream in-service register |
| mst_trig | output | 8 | Upstream trigger-mode register |
| slv_trig | output | 8 | Downstream trigger-mode register |

## Verification
Events, acknowledges and trigger writes land in registers at the first clock edge after they are driven. `pending`, `vec_valid`, `vector` and `win_line` follow combinationally from those registers and from the base, mask and cascade inputs. So every result is due one edge after its stimulus. A base or mask change alone shows up at once, with no edge. The bench drives inputs just after a rising edge and compares all outputs one time unit after the next rising edge. It keeps a shadow model that it advances at the same point.

// File: rtl/cascade_irq_resolver.sv
module cascade_irq_resolver #(
  parameter int              LINE_W        = 5,
  parameter int              CFG_AW        = 12,
  parameter logic [11:0]     MST_TRIG_ADDR = 12'h4D0,
  parameter logic [11:0]     SLV_TRIG_ADDR = 12'h4D1,
  parameter logic [7:0]      MST_TRIG_KEEP = 8'hF8,
  parameter logic [7:0]      SLV_TRIG_KEEP = 8'hDE,
  parameter int              CASCADE_PIN   = 2,
  parameter int              REDIRECT_LINE = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_raise,
  input  logic [LINE_W-1:0] ev_line,
  input  logic              ack,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [7:0]        mst_base,
  input  logic [7:0]        slv_base,
  input  logic [7:0]        mst_mask,
  input  logic [7:0]        slv_mask,
  input  logic [7:0]        cascade_map,
  output logic              pending,
  output logic              vec_valid,
  output logic [7:0]        vector,
  output logic [3:0]        win_line,
  output logic [7:0]        mst_req,
  output logic [7:0]        slv_req,
  output logic [7:0]        mst_isr,
  output logic [7:0]        slv_isr,
  output logic [7:0]        mst_trig,
  output logic [7:0]        slv_trig
);
  localparam int CHIP_N = 8;
  localparam int LINES  = 2 * CHIP_N;

  logic [7:0]        m_el, s_el;
  logic              s_open, found;
  logic [3:0]        win;
  logic [LINE_W-1:0] ev_tgt;
  logic [7:0]        mr_n, sr_n, mi_n, si_n;

  assign m_el    = mst_req & ~mst_mask & ~cascade_map;
  assign s_el    = slv_req & ~slv_mask;
  assign s_open  = ~mst_mask[CASCADE_PIN];
  assign pending = (|m_el) | (s_open & (|s_el));

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < CASCADE_PIN; i++)
      if (!found && m_el[i]) begin found = 1'b1; win = 4'(i); end
    for (int i = 0; i < CHIP_N; i++)
      if (!found && s_open && s_el[i]) begin found = 1'b1; win = 4'(CHIP_N + i); end
    for (int i = CASCADE_PIN + 1; i < CHIP_N; i++)
      if (!found && m_el[i]) begin found = 1'b1; win = 4'(i); end
  end

  assign vec_valid = found;
  assign win_line  = found ? win : 4'd0;
  assign vector    = !found ? 8'd0 :
                     win[3] ? slv_base + {5'd0, win[2:0]} : mst_base + {5'd0, win[2:0]};

  assign ev_tgt = (ev_line == LINE_W'(CASCADE_PIN)) ? LINE_W'(REDIRECT_LINE) : ev_line;

  always_comb begin
    mr_n = mst_req;
    sr_n = slv_req;
    mi_n = mst_isr;
    si_n = slv_isr;
    if (ack && found) begin
      if (!win[3]) begin
        mi_n[win[2:0]] = 1'b1;
        if (!mst_trig[win[2:0]]) mr_n[win[2:0]] = 1'b0;
      end else begin
        si_n[win[2:0]]    = 1'b1;
        mi_n[CASCADE_PIN] = 1'b1;
        if (!slv_trig[win[2:0]])   sr_n[win[2:0]]    = 1'b0;
        if (!mst_trig[CASCADE_PIN]) mr_n[CASCADE_PIN] = 1'b0;
      end
    end
    if (ev_valid && (ev_tgt < LINE_W'(LINES))) begin
      if (!ev_tgt[3]) begin
        mr_n[ev_tgt[2:0]] = ev_raise;
      end else begin
        sr_n[ev_tgt[2:0]] = ev_raise;
        if (ev_raise)                     mr_n[CASCADE_PIN] = 1'b1;
        else if ((sr_n & ~slv_mask) == '0) mr_n[CASCADE_PIN] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mst_req  <= '0;
      slv_req  <= '0;
      mst_isr  <= '0;
      slv_isr  <= '0;
      mst_trig <= '0;
      slv_trig <= '0;
    end else begin
      mst_req <= mr_n;
      slv_req <= sr_n;
      mst_isr <= mi_n;
      slv_isr <= si_n;
      if (cfg_wr && cfg_addr == MST_TRIG_ADDR) mst_trig <= cfg_wdata & MST_TRIG_KEEP;
      if (cfg_wr && cfg_addr == SLV_TRIG_ADDR) slv_trig <= cfg_wdata & SLV_TRIG_KEEP;
    end
  end

  // R11
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !vec_valid && !ev_valid |=> $stable(mst_req) && $stable(slv_req)
                                     && $stable(mst_isr) && $stable(slv_isr));

  // R4
  slv_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_raise && (ev_line[LINE_W-1:4] == '0)
      && (ev_line[3] || ev_line == LINE_W'(CASCADE_PIN)) |=> mst_req[CASCADE_PIN]);

  // R7
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> vector == 8'd0 && win_line == 4'd0);

  // R8
  mst_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && vec_valid && !win_line[3] |=> mst_isr[$past(win_line[2:0])]);

  // R9
  slv_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && vec_valid && win_line[3] |=> mst_isr[CASCADE_PIN] && slv_isr[$past(win_line[2:0])]);
endmodule

// File: tb/cascade_irq_resolver_bench.sv
module cascade_irq_resolver_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic ev_valid = 0, ev_raise = 0, ack = 0, cfg_wr = 0;
  logic [4:0]  ev_line = 0;
  logic [11:0] cfg_addr = 0;
  logic [7:0]  cfg_wdata = 0, mst_base = 0, slv_base = 0, mst_mask = 0, slv_mask = 0, cascade_map = 0;
  logic pending, vec_valid;
  logic [7:0] vector;
  logic [3:0] win_line;
  logic [7:0] mst_req, slv_req, mst_isr, slv_isr, mst_trig, slv_trig;

  int checks = 0, errors = 0;
  logic [7:0] e_mr, e_sr, e_mi, e_si, e_mt, e_st;

  always #5 clk = ~clk;

  cascade_irq_resolver u_cascade_irq_resolver (
    .clk, .rst_n, .ev_valid, .ev_raise, .ev_line, .ack, .cfg_wr, .cfg_addr, .cfg_wdata,
    .mst_base, .slv_base, .mst_mask, .slv_mask, .cascade_map,
    .pending, .vec_valid, .vector, .win_line,
    .mst_req, .slv_req, .mst_isr, .slv_isr, .mst_trig, .slv_trig);

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic exp_win(output bit f, output int l);
    logic [7:0] me, se;
    me = e_mr & ~mst_mask & ~cascade_map;
    se = e_sr & ~slv_mask;
    f = 0; l = 0;
    for (int i = 0; i < 2; i++) if (!f && me[i]) begin f = 1; l = i; end
    for (int i = 0; i < 8; i++) if (!f && !mst_mask[2] && se[i]) begin f = 1; l = 8 + i; end
    for (int i = 3; i < 8; i++) if (!f && me[i]) begin f = 1; l = i; end
  endtask

  task automatic chk_all(string tag);
    bit f; int l; bit p; int v;
    exp_win(f, l);
    p = (|(e_mr & ~mst_mask & ~cascade_map)) || (!mst_mask[2] && |(e_sr & ~slv_mask));
    v = !f ? 0 : (l >= 8) ? ((slv_base + l - 8) & 255) : ((mst_base + l) & 255);
    cmp(tag, "mst_req", mst_req, e_mr);
    cmp(tag, "slv_req", slv_req, e_sr);
    cmp(tag, "mst_isr", mst_isr, e_mi);
    cmp(tag, "slv_isr", slv_isr, e_si);
    cmp(tag, "mst_trig", mst_trig, e_mt);
    cmp(tag, "slv_trig", slv_trig, e_st);
    cmp(tag, "pending", pending, p);
    cmp(tag, "vec_valid", vec_valid, f);
    cmp(tag, "win_line", win_line, f ? l : 0);
    cmp(tag, "vector", vector, v);
  endtask

  task automatic do_reset();
    rst_n = 0;
    mst_mask = 0; slv_mask = 0; cascade_map = 0; mst_base = 8'h08; slv_base = 8'h70;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    e_mr = 0; e_sr = 0; e_mi = 0; e_si = 0; e_mt = 0; e_st = 0;
  endtask

  task automatic op(bit ev, bit rz, int ln, bit ak);
    bit f; int l; int t;
    ev_valid = ev; ev_raise = rz; ev_line = ln[4:0]; ack = ak;
    exp_win(f, l);
    if (ak && f) begin
      if (l < 8) begin
        e_mi[l] = 1;
        if (!e_mt[l]) e_mr[l] = 0;
      end else begin
        e_si[l-8] = 1; e_mi[2] = 1;
        if (!e_st[l-8]) e_sr[l-8] = 0;
        if (!e_mt[2]) e_mr[2] = 0;
      end
    end
    if (ev) begin
      t = (ln == 2) ? 9 : ln;
      if (t < 8) e_mr[t] = rz;
      else if (t < 16) begin
        e_sr[t-8] = rz;
        if (rz) e_mr[2] = 1;
        else if ((e_sr & ~slv_mask) == 0) e_mr[2] = 0;
      end
    end
    @(posedge clk); #1;
    ev_valid = 0; ack = 0;
  endtask

  task automatic wr_trig(int addr, int data);
    cfg_wr = 1; cfg_addr = addr[11:0]; cfg_wdata = data[7:0];
    if (addr == 12'h4D0) e_mt = data[7:0] & 8'hF8;
    if (addr == 12'h4D1) e_st = data[7:0] & 8'hDE;
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  function automatic string ev_tag(int l);
    if (l == 2) return "R3";
    if (l >= 8 && l < 16) return "R4";
    return "R2";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk_all("R1");

    // R2 R3 R4 R8 R9: raise, acknowledge and lower every line number
    for (int l = 0; l < 32; l++) begin
      do_reset();
      op(1, 1, l, 0); chk_all(ev_tag(l));
      op(0, 0, 0, 1); chk_all((l >= 8 && l < 16) || l == 2 ? "R9" : "R8");
      op(1, 0, l, 0); chk_all(ev_tag(l));
    end

    // R6: every ordered pair of lines
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        do_reset();
        op(1, 1, a, 0);
        op(1, 1, b, 0); chk_all("R6");
      end

    // R5 R7 R8 R9: mask, cascade and base patterns
    for (int i = 0; i < 64; i++) begin
      do_reset();
      mst_mask = 8'((i * 37) & 8'hFB) | (i[3] ? 8'h04 : 8'h00);
      slv_mask = 8'((i * 91) ^ 8'h5A);
      cascade_map = i[0] ? 8'h04 : (i[1] ? 8'h28 : 8'h00);
      op(1, 1, i % 16, 0);
      op(1, 1, (i * 7) % 16, 0);
      op(1, 1, (i * 3 + 5) % 16, 0); chk_all("R5");
      op(0, 0, 0, 1); chk_all((i % 2) ? "R9" : "R8");
      mst_base = 8'(i * 8); slv_base = 8'(8'hF8 + i); #1;
      chk_all("R7");
    end

    // R10: trigger-mode writes
    do_reset();
    wr_trig(12'h4D0, 8'hFF); chk_all("R10");
    wr_trig(12'h4D1, 8'hFF); chk_all("R10");
    wr_trig(12'h4D2, 8'h00); chk_all("R10");
    wr_trig(12'h0D0, 8'h00); chk_all("R10");
    op(1, 1, 3, 0); op(0, 0, 0, 1); chk_all("R8");
    op(1, 0, 3, 0);
    op(1, 1, 9, 0); op(0, 0, 0, 1); chk_all("R9");
    op(1, 1, 8, 0); op(0, 0, 0, 1); chk_all("R9");
    wr_trig(12'h4D1, 8'h21); chk_all("R10");

    // R4: lowering with other downstream requests open or masked
    do_reset();
    op(1, 1, 9, 0); op(1, 1, 10, 0);
    op(1, 0, 9, 0); chk_all("R4");
    op(1, 0, 10, 0); chk_all("R4");
    do_reset();
    op(1, 1, 9, 0); op(1, 1, 10, 0);
    slv_mask = 8'h04;
    op(1, 0, 9, 0); chk_all("R4");

    // R11: acknowledge with no winner
    do_reset();
    op(0, 0, 0, 1); chk_all("R11");
    op(1, 1, 3, 0);
    mst_mask = 8'hFF;
    op(0, 0, 0, 1); chk_all("R11");
    op(1, 1, 12, 0);
    op(0, 0, 0, 1); chk_all("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule